// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block steps through a multi-register memory transfer. A single start pulse presents a word-aligned base address, a 16-bit mask that marks which registers take part, a direction bit, a before/after bit and a write-back enable. The sequencer then issues one transfer per clock cycle. Each transfer carries a register index and the word address that register uses, and is marked by a valid strobe. After the last transfer it raises a one-cycle done pulse and presents the base value that should be written back. The block only produces addresses and register indices. The memory access and the register-file access are made by logic outside it.

The four addressing variants differ only in the address window they cover. The rule for ordering within that window is the same in all four: registers are visited in ascending index order at ascending word addresses, so the lowest-numbered register always takes the lowest address. This lets one sequencer serve both kinds of stack. For a stack that grows downward with the pointer on the last used slot, a push uses decrement-before and a pop uses increment-after. The other stack disciplines are served by the remaining pairs in the same way.

Top module: `blkxfer_addr_seq`

## Requirements
- R1: Synchronous active-high reset clears the block. While it is idle after reset, xfer_valid and done are 0 and new_base is 0.
- R2: A start sampled while no transfers are in progress produces exactly N transfers, where N is the number of 1 bits in reg_mask. They come on N consecutive cycles, and the first is visible in the cycle after the start edge.
- R3: Transfers visit the set bits of reg_mask in ascending index order. Each transfer's address is 4 greater than the address of the transfer before it, so the lowest register always sits at the lowest address.
- R4: The first address depends on the mode. With step_up=1 and pre_step=0 it is base. With step_up=1 and pre_step=1 it is base+4. With step_up=0 and pre_step=0 it is base−4N+4. With step_up=0 and pre_step=1 it is base−4N.
- R5: With wb_en=1, new_base at done equals base+4N when step_up=1 and base−4N when step_up=0.
- R6: With wb_en=0, new_base at done equals the original base, whatever the mode.
- R7: done is high for exactly one cycle, in the cycle right after the last transfer. It is never high in the same cycle as xfer_valid.
- R8: An all-zero reg_mask produces no transfer. done is high in the cycle after the start edge, and new_base equals base.
- R9: A start pulse that arrives while transfers are in progress is ignored. The running sequence goes on unchanged, and no further sequence follows it.
- R10: A start sampled in the done cycle is accepted. Its first transfer appears in the next cycle.
- R11: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; sampled when no transfers are running |
| base_addr | input | 32 | Base byte address of the block |
| reg_mask | input | 16 | Bit i set means register i takes part |
| step_up | input | 1 | 1 = addresses above base, 0 = addresses below base |
| pre_step | input | 1 | 1 = step before the first access, 0 = step after each access |
| wb_en | input | 1 | 1 = new_base carries the stepped base, 0 = the original base |
| xfer_valid | output | 1 | A transfer is presented this cycle |
| xfer_reg | output | 4 | Register index of the current transfer |
| xfer_addr | output | 32 | Word address of the current transfer |
| done | output | 1 | One-cycle pulse after the last transfer |
| new_base | output | 32 | Base value for write-back, valid while done is high |

## Verification
Two events can fall in the same cycle: the done pulse that ends one sequence and the acceptance of the next start. The bench provokes this by raising start in the very cycle in which it sees done. It judges the result by requiring the first transfer of the new sequence in the next cycle, with the new mode's addresses and with done already low. A second overlap is a start raised while transfers are still running. Here the running sequence must complete with its own indices and addresses, and no further transfer may follow its done pulse.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned NREG       = 16;
    localparam int unsigned WORD_BYTES = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic up;
        logic pre;
        logic wb;
    } xfer_mode_t;

endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
    parameter int unsigned W  = 16,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] part [W+1];

    assign part[0] = '0;
    for (genvar i = 0; i < W; i++) begin : g_sum
        assign part[i+1] = part[i] + CW'(vec[i]);
    end
    assign cnt = part[W];
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
    parameter int unsigned W  = 16,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] chain [W+1];

    assign chain[W] = '0;
    for (genvar i = W - 1; i >= 0; i--) begin : g_pick
        assign chain[i] = vec[i] ? IW'(i) : chain[i+1];
    end
    assign idx = chain[0];
endmodule

// File: rtl/blkxfer_addr_calc.sv
module blkxfer_addr_calc
    import blkxfer_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 5,
    parameter int unsigned WB = 4
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  xfer_mode_t    mode,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] wb_base
);
    localparam int unsigned SH = $clog2(WB);
    localparam logic [AW-1:0] STEP = AW'(WB);

    logic [AW-1:0] span;
    logic [AW-1:0] low_base;
    logic [AW-1:0] end_base;

    assign span     = AW'(count) << SH;
    assign low_base = base - span;

    always_comb begin
        if (mode.up) begin
            first_addr = mode.pre ? base + STEP : base;
            end_base   = base + span;
        end else begin
            first_addr = mode.pre ? low_base : low_base + STEP;
            end_base   = low_base;
        end
        wb_base = mode.wb ? end_base : base;
    end
endmodule

// File: rtl/blkxfer_addr_seq.sv
module blkxfer_addr_seq
    import blkxfer_pkg::*;
#(
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned NR    = NREG,
    parameter int unsigned WBYTE = WORD_BYTES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [AW-1:0]         base_addr,
    input  logic [NR-1:0]         reg_mask,
    input  logic                  step_up,
    input  logic                  pre_step,
    input  logic                  wb_en,
    output logic                  xfer_valid,
    output logic [$clog2(NR)-1:0] xfer_reg,
    output logic [AW-1:0]         xfer_addr,
    output logic                  done,
    output logic [AW-1:0]         new_base
);
    localparam int unsigned IW = $clog2(NR);
    localparam int unsigned CW = $clog2(NR + 1);
    localparam logic [AW-1:0] STEP = AW'(WBYTE);

    seq_state_e    state_q;
    logic [NR-1:0] mask_q;
    logic [NR-1:0] mask_next;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] nb_q;
    logic [CW-1:0] count;
    logic [AW-1:0] first_addr;
    logic [AW-1:0] wb_base;
    xfer_mode_t    cmd_mode;
    logic          accept;

    assign cmd_mode = '{up: step_up, pre: pre_step, wb: wb_en};

    blkxfer_popcnt #(.W(NR), .CW(CW)) u_cnt (
        .vec (reg_mask),
        .cnt (count)
    );

    blkxfer_addr_calc #(.AW(AW), .CW(CW), .WB(WBYTE)) u_calc (
        .base       (base_addr),
        .count      (count),
        .mode       (cmd_mode),
        .first_addr (first_addr),
        .wb_base    (wb_base)
    );

    blkxfer_lowbit #(.W(NR), .IW(IW)) u_low (
        .vec (mask_q),
        .idx (xfer_reg)
    );

    assign mask_next = mask_q & (mask_q - NR'(1));
    assign accept    = start && (state_q != SEQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            mask_q  <= '0;
            addr_q  <= '0;
            nb_q    <= '0;
        end else if (accept) begin
            mask_q  <= reg_mask;
            addr_q  <= first_addr;
            nb_q    <= wb_base;
            state_q <= (reg_mask == '0) ? SEQ_FIN : SEQ_RUN;
        end else begin
            unique case (state_q)
                SEQ_RUN: begin
                    mask_q <= mask_next;
                    addr_q <= addr_q + STEP;
                    if (mask_next == '0) begin
                        state_q <= SEQ_FIN;
                    end
                end
                SEQ_FIN:  state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign xfer_valid = (state_q == SEQ_RUN);
    assign done       = (state_q == SEQ_FIN);
    assign xfer_addr  = addr_q;
    assign new_base   = nb_q;
endmodule

// File: rtl/blkxfer_addr_seq_chk.sv
module blkxfer_addr_seq_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned NR = 16,
    parameter int unsigned WB = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  xfer_valid,
    input logic [$clog2(NR)-1:0] xfer_reg,
    input logic [AW-1:0]         xfer_addr,
    input logic                  done
);
    // R2
    valid_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_valid) |-> $past(start));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && $past(xfer_valid)) |-> (xfer_addr == $past(xfer_addr) + AW'(WB)));

    // R3
    reg_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && $past(xfer_valid)) |-> (xfer_reg > $past(xfer_reg)));

    // R7
    valid_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(xfer_valid && done));

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer_valid) |-> done);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);
endmodule

bind blkxfer_addr_seq blkxfer_addr_seq_chk #(.AW(AW), .NR(NR), .WB(WBYTE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .xfer_valid (xfer_valid),
    .xfer_reg   (xfer_reg),
    .xfer_addr  (xfer_addr),
    .done       (done)
);

// File: tb/tb_blkxfer_addr_seq.sv
module tb_blkxfer_addr_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] reg_mask = '0;
    logic        step_up = 1'b0;
    logic        pre_step = 1'b0;
    logic        wb_en = 1'b0;
    logic        xfer_valid;
    logic [3:0]  xfer_reg;
    logic [31:0] xfer_addr;
    logic        done;
    logic [31:0] new_base;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    blkxfer_addr_seq dut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .reg_mask(reg_mask), .step_up(step_up), .pre_step(pre_step),
        .wb_en(wb_en), .xfer_valid(xfer_valid), .xfer_reg(xfer_reg),
        .xfer_addr(xfer_addr), .done(done), .new_base(new_base)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int ones(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    // Called just after a negedge; returns just after the negedge that shows done.
    task automatic run_op(input logic [31:0] b, input logic [15:0] m, input bit up,
                          input bit pre, input bit wb, input bit poke, input string base_tag);
        int n = ones(m);
        int r = 0;
        logic [31:0] lo;
        logic [31:0] fin;
        if (up) begin
            lo  = pre ? b + 32'd4 : b;
            fin = b + 32'(4 * n);
        end else begin
            lo  = pre ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4;
            fin = b - 32'(4 * n);
        end
        if (!wb) fin = b;
        base_addr = b; reg_mask = m; step_up = up; pre_step = pre; wb_en = wb;
        start = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) start = 1'b0;
            while (!m[r]) r++;
            check("R2 xfer_valid", {31'd0, xfer_valid}, 32'd1);
            check("R3 xfer_reg order", {28'd0, xfer_reg}, 32'(r));
            check(k == 0 ? "R4 first address" : "R3 address step", xfer_addr, lo + 32'(4 * k));
            check("R7 done low during transfers", {31'd0, done}, 32'd0);
            r++;
            if (poke && k == 1) begin
                start = 1'b1; base_addr = 32'hDEAD_0000; reg_mask = 16'h8001;
                step_up = ~up; wb_en = 1'b0;
            end
            if (poke && k == 2) start = 1'b0;
        end
        @(negedge clk);
        if (n == 0) start = 1'b0;
        check("R7 valid low at done", {31'd0, xfer_valid}, 32'd0);
        check(n == 0 ? "R8 done after empty" : "R7 done after last", {31'd0, done}, 32'd1);
        check(base_tag, new_base, fin);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 xfer_valid after reset", {31'd0, xfer_valid}, 32'd0);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        check("R1 new_base after reset", new_base, 32'd0);
    endtask

    task automatic t_four_modes();
        run_op(32'h1000, 16'h0023, 1, 0, 1, 0, "R5 inc-after base"); @(negedge clk);
        run_op(32'h1000, 16'h0023, 1, 1, 1, 0, "R5 inc-before base"); @(negedge clk);
        run_op(32'h1000, 16'h0023, 0, 0, 1, 0, "R5 dec-after base"); @(negedge clk);
        run_op(32'h1000, 16'h0023, 0, 1, 1, 0, "R5 dec-before base"); @(negedge clk);
    endtask

    task automatic t_full_and_single();
        run_op(32'h2000, 16'hFFFF, 1, 0, 1, 0, "R5 full list base"); @(negedge clk);
        run_op(32'h3000, 16'h8000, 0, 1, 1, 0, "R5 single r15 base"); @(negedge clk);
    endtask

    task automatic t_no_wb();
        run_op(32'h4440, 16'h0F0F, 0, 0, 0, 0, "R6 no write-back dec"); @(negedge clk);
        run_op(32'h4440, 16'h00C1, 1, 1, 0, 0, "R6 no write-back inc"); @(negedge clk);
    endtask

    task automatic t_empty();
        run_op(32'h5550, 16'h0000, 0, 1, 1, 0, "R8 empty base");
        @(negedge clk);
        check("R8 no transfer after empty", {31'd0, xfer_valid}, 32'd0);
        check("R7 done single cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_busy_start();
        run_op(32'h6000, 16'h1249, 1, 1, 1, 1, "R9 base after ignored start");
        @(negedge clk);
        check("R9 no sequence from ignored start", {31'd0, xfer_valid}, 32'd0);
        check("R9 no second done", {31'd0, done}, 32'd0);
    endtask

    task automatic t_chain();
        run_op(32'h7000, 16'h0006, 1, 0, 1, 0, "R5 chain first base");
        run_op(32'h7100, 16'h0300, 0, 1, 1, 0, "R10 chained op base");
        @(negedge clk);
    endtask

    task automatic t_wrap();
        run_op(32'h0000_0004, 16'h00F0, 0, 1, 1, 0, "R11 wrapped base"); @(negedge clk);
        run_op(32'hFFFF_FFF8, 16'h0007, 1, 0, 1, 0, "R11 wrapped up base"); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_four_modes();
        t_full_and_single();
        t_no_wb();
        t_empty();
        t_busy_start();
        t_chain();
        t_wrap();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule